// File: doc/BRIEF.md
# I2C Command Register Front End

This block is the processor-facing half of a short-command I2C controller. Software programs clock and bus settings, a target address and up to eight payload bytes into a small bus-slave register file. It then writes a single command word that names the transfer kind and the byte counts. That write launches the transfer on a separate I2C engine through a one-cycle start pulse. The engine later answers with a done pulse, a set of outcome flags and any received bytes.

The front end keeps the command fields and the payload stable for the engine while the transfer runs. It converts between the right-aligned byte layout software uses and the first-byte-first layout the engine uses. When the engine answers, it records the outcome as write-1-to-clear status flags and stores the received bytes. A masked level interrupt tells the processor that something needs attention. Only one command runs at a time. A command written too early is refused, and the refusal is reported in the status register.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: After reset, the register at offset 0x00 and the one at 0x04 read 0x0000301F, offset 0x08 reads 0x00003302, and the registers at offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 read 0. After reset, irq and eng_start are 0.
- R2: The two clock registers (0x00 and 0x04) keep only bits 15:12 and 9:0. The configuration register (0x08) keeps only bits 15:4, 1 and 0. All other bits of these three registers read as 0.
- R3: A write to the command register (0x0C) while idle with kind bits 9:8 equal to 0 (write), 1 (read) or 2 (write then read) is accepted. One cycle later eng_start is high for exactly one cycle, the busy register (0x24) reads 1, and eng_kind, eng_wcnt_m1 and eng_rcnt_m1 carry bits 9:8, 6:4 and 2:0 of the written word.
- R4: When configuration bit 7 is 1, eng_taddr is the 10-bit value of the address register (0x10). When bit 7 is 0, eng_taddr is the low 7 bits of that register with the upper bits zero. The address register always reads back all 10 stored bits.
- R5: For a write or write-then-read command with W = eng_wcnt_m1 + 1, byte k of eng_tx (bits 8k+7:8k, the k-th byte to send) equals payload byte W-1-k. Payload bytes 0 to 3 are bits 7:0 up to 31:24 of data word 0 (0x14), and bytes 4 to 7 are the same positions of data word 1 (0x18). Bytes k >= W of eng_tx are 0, and eng_tx is 0 for a read-only command.
- R6: An eng_done pulse while busy clears the busy register and sets status bit 0 (done). It also sets status bits 1 to 4 wherever eng_err bits 0 to 3 are 1 (lost arbitration, no response, data collision, bus busy). Every flag present is set, not only the highest-priority one.
- R7: On completion of a read or write-then-read command with R = eng_rcnt_m1 + 1, the k-th received byte (eng_rx byte k) is stored as payload byte R-1-k, and payload bytes at R and above become 0. A write-only completion leaves both data words unchanged.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it alone. A flag set by an event in the same cycle as its clearing write stays set.
- R9: irq is 1 exactly when some status bit and its mask bit (0x20, bits 4:0) are both 1.
- R10: A command write while busy starts nothing, leaves eng_kind, eng_wcnt_m1 and eng_rcnt_m1 unchanged, and sets status bit 4.
- R11: A command write with kind bits 9:8 equal to 3 is ignored: no eng_start, the busy register stays 0, and the status register is unchanged.
- R12: Writes to data word 0 or data word 1 while busy are ignored.
- R13: An eng_done pulse while idle changes neither the status register nor the busy register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_off (combinational) |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_kind | output | 2 | Transfer kind of the running command |
| eng_wcnt_m1 | output | 3 | Bytes to send minus one |
| eng_rcnt_m1 | output | 3 | Bytes to receive minus one |
| eng_taddr | output | 10 | Target address as the engine uses it |
| eng_clk_sf | output | 16 | Standard/fast clock setup |
| eng_clk_hs | output | 16 | High-speed clock setup |
| eng_cfg | output | 16 | Configuration word |
| eng_tx | output | 64 | Bytes to send, byte 0 first |
| eng_done | input | 1 | Engine finished the running command |
| eng_err | input | 4 | Outcome flags valid with eng_done |
| eng_rx | input | 64 | Received bytes, byte 0 first received |

## Verification
The transfer path is exercised with a 4-byte write, a 3-byte read and a full 8-byte write-then-read. Across these three, the byte counts separate a byte reversal done correctly from one done over the whole 64 bits or with a wrong count, and the garbage placed above the valid receive bytes shows whether unused bytes are zeroed. Completions use no error, then several error flags together, which separates setting every flag from keeping only the highest-priority one. Commands are also written while busy, with the reserved kind, and in the same cycle as a clearing write. These cases separate refusal, ignoring, and set-over-clear precedence from each other.

// File: rtl/icf_pkg.sv
// Package for the I2C command front end: register offsets, field positions,
// reset values, shared types and the byte-order conversion function.
package icf_pkg;
    localparam int BUS_W     = 32;
    localparam int OFF_W     = 6;
    localparam int MAX_BYTES = 8;
    localparam int PAY_W     = MAX_BYTES * 8;
    localparam int CNT_W     = $clog2(MAX_BYTES);
    localparam int TADDR_W   = 10;
    localparam int SADDR_W   = 7;
    localparam int NERR      = 4;
    localparam int STS_W     = NERR + 1;
    localparam int REG_W     = 16;

    localparam logic [OFF_W-1:0] OFF_CLK_SF = 6'h00;
    localparam logic [OFF_W-1:0] OFF_CLK_HS = 6'h04;
    localparam logic [OFF_W-1:0] OFF_CFG    = 6'h08;
    localparam logic [OFF_W-1:0] OFF_CMD    = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_TADDR  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_WORD0  = 6'h14;
    localparam logic [OFF_W-1:0] OFF_WORD1  = 6'h18;
    localparam logic [OFF_W-1:0] OFF_STS    = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_MSK    = 6'h20;
    localparam logic [OFF_W-1:0] OFF_BUSY   = 6'h24;

    localparam logic [REG_W-1:0] CLK_KEEP = 16'hF3FF;
    localparam logic [REG_W-1:0] CLK_RST  = 16'h301F;
    localparam logic [REG_W-1:0] CFG_KEEP = 16'hFFF3;
    localparam logic [REG_W-1:0] CFG_RST  = 16'h3302;
    localparam int CFG_TEN_BIT = 7;

    localparam int CMD_KIND_LSB = 8;
    localparam int CMD_WCNT_LSB = 4;
    localparam int CMD_RCNT_LSB = 0;

    localparam int STS_DONE    = 0;
    localparam int STS_BUSHIT  = 4;

    typedef enum logic [1:0] {
        XK_WRITE  = 2'd0,
        XK_READ   = 2'd1,
        XK_WRREAD = 2'd2,
        XK_RSVD   = 2'd3
    } xkind_e;

    typedef struct packed {
        xkind_e             kind;
        logic [CNT_W-1:0]   wcnt_m1;
        logic [CNT_W-1:0]   rcnt_m1;
    } cmd_t;

    // Mirror the lowest n_m1+1 bytes of src (byte k <-> byte n_m1-k); other bytes zero.
    function automatic logic [PAY_W-1:0] mirror_bytes(input logic [PAY_W-1:0] src,
                                                       input logic [CNT_W-1:0] n_m1);
        logic [PAY_W-1:0] res;
        res = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k <= int'(n_m1)) begin
                res[8*k +: 8] = src[8*(int'(n_m1) - k) +: 8];
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/icf_cfg_regs.sv
// Setup register bank: two clock words, the configuration word and the target
// address. Assumes writes arrive as single-cycle strobes. It derives the address
// the engine sees from the 10-bit flag in the configuration word.
module icf_cfg_regs
    import icf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_clk_sf,
    input  logic                 wr_clk_hs,
    input  logic                 wr_cfg,
    input  logic                 wr_taddr,
    input  logic [BUS_W-1:0]     wdata,
    output logic [REG_W-1:0]     clk_sf,
    output logic [REG_W-1:0]     clk_hs,
    output logic [REG_W-1:0]     cfg,
    output logic [TADDR_W-1:0]   taddr,
    output logic [TADDR_W-1:0]   eng_taddr
);
    // Register writes with the defined-field masks applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sf <= CLK_RST;
            clk_hs <= CLK_RST;
            cfg    <= CFG_RST;
            taddr  <= '0;
        end else begin
            if (wr_clk_sf) clk_sf <= wdata[REG_W-1:0] & CLK_KEEP;
            if (wr_clk_hs) clk_hs <= wdata[REG_W-1:0] & CLK_KEEP;
            if (wr_cfg)    cfg    <= wdata[REG_W-1:0] & CFG_KEEP;
            if (wr_taddr)  taddr  <= wdata[TADDR_W-1:0];
        end
    end

    // Address seen by the engine: full 10 bits or low 7 bits only.
    always_comb begin
        if (cfg[CFG_TEN_BIT]) eng_taddr = taddr;
        else                  eng_taddr = {{(TADDR_W-SADDR_W){1'b0}}, taddr[SADDR_W-1:0]};
    end

    p_short_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[CFG_TEN_BIT]) |-> (eng_taddr[TADDR_W-1:SADDR_W] == '0))
        else $error("R4: short address has upper bits set");

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_taddr) |=> $stable(taddr))
        else $error("R4: address register changed without a write");
endmodule

// File: rtl/icf_seq.sv
// Command sequencer: accepts a command word when idle, holds its fields, raises
// a one-cycle start pulse and waits for the engine's done pulse. Assumes the
// engine answers each start with exactly one done pulse.
module icf_seq
    import icf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 eng_done,
    output logic                 busy,
    output logic                 start,
    output cmd_t                 cmd,
    output logic                 done_evt,
    output logic                 busy_hit
);
    logic   accept;
    xkind_e new_kind;

    assign new_kind = xkind_e'(wdata[CMD_KIND_LSB +: 2]);
    assign accept   = cmd_wr && !busy && (new_kind != XK_RSVD);
    assign done_evt = busy && eng_done;
    assign busy_hit = cmd_wr && busy;

    // Busy flag, start pulse and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            start <= 1'b0;
            cmd   <= '0;
        end else begin
            start <= accept;
            if (accept) begin
                busy        <= 1'b1;
                cmd.kind    <= new_kind;
                cmd.wcnt_m1 <= wdata[CMD_WCNT_LSB +: CNT_W];
                cmd.rcnt_m1 <= wdata[CMD_RCNT_LSB +: CNT_W];
            end else if (done_evt) begin
                busy <= 1'b0;
            end
        end
    end

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start)
        else $error("R3: start pulse longer than one cycle");

    p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_evt) |=> $stable(cmd))
        else $error("R10: command fields changed while busy");

    p_idle_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && eng_done && !cmd_wr) |=> !busy)
        else $error("R13: idle done pulse changed busy");

    p_rsvd_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && new_kind == XK_RSVD) |=> (!busy && !start))
        else $error("R11: reserved kind started a transfer");
endmodule

// File: rtl/icf_data_path.sv
// Payload words: software-visible right-aligned layout on one side, engine
// first-byte-first layout on the other. Assumes the command fields stay stable
// while busy. Received bytes are loaded on completion of a read-type command.
module icf_data_path
    import icf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_word0,
    input  logic                 wr_word1,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 busy,
    input  logic                 done_evt,
    input  cmd_t                 cmd,
    input  logic [PAY_W-1:0]     eng_rx,
    output logic [BUS_W-1:0]     word0,
    output logic [BUS_W-1:0]     word1,
    output logic [PAY_W-1:0]     eng_tx
);
    logic             load_rx;
    logic [PAY_W-1:0] rx_packed;

    assign load_rx   = done_evt && (cmd.kind != XK_WRITE);
    assign rx_packed = mirror_bytes(eng_rx, cmd.rcnt_m1);

    // Data words: received bytes on completion, software writes only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0 <= '0;
            word1 <= '0;
        end else if (load_rx) begin
            word0 <= rx_packed[BUS_W-1:0];
            word1 <= rx_packed[PAY_W-1:BUS_W];
        end else if (!busy) begin
            if (wr_word0) word0 <= wdata;
            if (wr_word1) word1 <= wdata;
        end
    end

    // Bytes to send in transmit order; nothing to send for a read-only command.
    always_comb begin
        if (cmd.kind == XK_READ) eng_tx = '0;
        else                     eng_tx = mirror_bytes({word1, word0}, cmd.wcnt_m1);
    end

    p_hold_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_evt) |=> ($stable(word0) && $stable(word1)))
        else $error("R12: data words changed while busy");

    p_write_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && cmd.kind == XK_WRITE) |=> ($stable(word0) && $stable(word1)))
        else $error("R7: write-only completion touched the data words");

    p_full_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rx && cmd.rcnt_m1 == 3'd7) |=> (word0[7:0] == $past(eng_rx[63:56])))
        else $error("R7: last received byte not in bits 7:0");
endmodule

// File: rtl/icf_status.sv
// Outcome flags, interrupt mask and interrupt line. Flags are set by completion
// and refused commands and cleared by writing 1; a set in the same cycle as a
// clear wins. The interrupt is a level derived from the flags and the mask.
module icf_status
    import icf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sts,
    input  logic                 wr_msk,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 done_evt,
    input  logic [NERR-1:0]      eng_err,
    input  logic                 busy_hit,
    output logic [STS_W-1:0]     sts,
    output logic [STS_W-1:0]     msk,
    output logic                 irq
);
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;

    // Flags raised this cycle by completion and by a refused command.
    always_comb begin
        set_vec = '0;
        if (done_evt) set_vec = {eng_err, 1'b1};
        if (busy_hit) set_vec[STS_BUSHIT] = 1'b1;
    end

    assign clr_vec = wr_sts ? wdata[STS_W-1:0] : '0;

    // Flag and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            msk <= '0;
        end else begin
            sts <= (sts & ~clr_vec) | set_vec;
            if (wr_msk) msk <= wdata[STS_W-1:0];
        end
    end

    assign irq = |(sts & msk);

    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> sts[STS_DONE])
        else $error("R6: done flag not set on completion");

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[STS_DONE] && !done_evt) |=> !sts[STS_DONE])
        else $error("R8: done flag survived a clearing write");

    p_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_hit |=> sts[STS_BUSHIT])
        else $error("R10: refused command not flagged");

    p_no_spurious_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_evt && !busy_hit) |=> ((sts & ~$past(sts)) == '0))
        else $error("R13: flag set without an event");
endmodule

// File: rtl/i2c_cmd_frontend.sv
// Top of the I2C command front end: register decode and read mux around the
// setup bank, sequencer, payload path and status block. Assumes single-cycle
// register accesses at word-aligned offsets; reads are combinational.
module i2c_cmd_frontend
    import icf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [5:0]           bus_off,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq,
    output logic                 eng_start,
    output logic [1:0]           eng_kind,
    output logic [2:0]           eng_wcnt_m1,
    output logic [2:0]           eng_rcnt_m1,
    output logic [9:0]           eng_taddr,
    output logic [15:0]          eng_clk_sf,
    output logic [15:0]          eng_clk_hs,
    output logic [15:0]          eng_cfg,
    output logic [63:0]          eng_tx,
    input  logic                 eng_done,
    input  logic [3:0]           eng_err,
    input  logic [63:0]          eng_rx
);
    logic                 wr_any;
    logic                 busy, done_evt, busy_hit;
    cmd_t                 cmd;
    logic [TADDR_W-1:0]   taddr;
    logic [BUS_W-1:0]     word0, word1;
    logic [STS_W-1:0]     sts, msk;

    assign wr_any = bus_sel && bus_wr;

    icf_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_clk_sf (wr_any && bus_off == OFF_CLK_SF),
        .wr_clk_hs (wr_any && bus_off == OFF_CLK_HS),
        .wr_cfg    (wr_any && bus_off == OFF_CFG),
        .wr_taddr  (wr_any && bus_off == OFF_TADDR),
        .wdata     (bus_wdata),
        .clk_sf    (eng_clk_sf),
        .clk_hs    (eng_clk_hs),
        .cfg       (eng_cfg),
        .taddr     (taddr),
        .eng_taddr (eng_taddr)
    );

    icf_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_any && bus_off == OFF_CMD),
        .wdata    (bus_wdata),
        .eng_done (eng_done),
        .busy     (busy),
        .start    (eng_start),
        .cmd      (cmd),
        .done_evt (done_evt),
        .busy_hit (busy_hit)
    );

    icf_data_path u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_word0 (wr_any && bus_off == OFF_WORD0),
        .wr_word1 (wr_any && bus_off == OFF_WORD1),
        .wdata    (bus_wdata),
        .busy     (busy),
        .done_evt (done_evt),
        .cmd      (cmd),
        .eng_rx   (eng_rx),
        .word0    (word0),
        .word1    (word1),
        .eng_tx   (eng_tx)
    );

    icf_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sts   (wr_any && bus_off == OFF_STS),
        .wr_msk   (wr_any && bus_off == OFF_MSK),
        .wdata    (bus_wdata),
        .done_evt (done_evt),
        .eng_err  (eng_err),
        .busy_hit (busy_hit),
        .sts      (sts),
        .msk      (msk),
        .irq      (irq)
    );

    assign eng_kind    = cmd.kind;
    assign eng_wcnt_m1 = cmd.wcnt_m1;
    assign eng_rcnt_m1 = cmd.rcnt_m1;

    // Read mux over all registers; the command register reads as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_off)
            OFF_CLK_SF: bus_rdata = {{(BUS_W-REG_W){1'b0}}, eng_clk_sf};
            OFF_CLK_HS: bus_rdata = {{(BUS_W-REG_W){1'b0}}, eng_clk_hs};
            OFF_CFG:    bus_rdata = {{(BUS_W-REG_W){1'b0}}, eng_cfg};
            OFF_TADDR:  bus_rdata = {{(BUS_W-TADDR_W){1'b0}}, taddr};
            OFF_WORD0:  bus_rdata = word0;
            OFF_WORD1:  bus_rdata = word1;
            OFF_STS:    bus_rdata = {{(BUS_W-STS_W){1'b0}}, sts};
            OFF_MSK:    bus_rdata = {{(BUS_W-STS_W){1'b0}}, msk};
            OFF_BUSY:   bus_rdata = {{(BUS_W-1){1'b0}}, busy};
            default:    bus_rdata = '0;
        endcase
    end

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msk == '0) |-> !irq)
        else $error("R9: interrupt with all sources masked");

    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (busy && $past(!busy)))
        else $error("R3: start without an idle-to-busy change");
endmodule

// File: tb/tb_i2c_cmd_frontend.sv
// Bench: behavioural reference model updated on every rising edge and compared
// on every falling edge, plus directed register checks.
module tb_i2c_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start;
    logic [1:0]  eng_kind;
    logic [2:0]  eng_wcnt_m1, eng_rcnt_m1;
    logic [9:0]  eng_taddr;
    logic [15:0] eng_clk_sf, eng_clk_hs, eng_cfg;
    logic [63:0] eng_tx;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_err = '0;
    logic [63:0] eng_rx = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    i2c_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_kind(eng_kind),
        .eng_wcnt_m1(eng_wcnt_m1), .eng_rcnt_m1(eng_rcnt_m1),
        .eng_taddr(eng_taddr), .eng_clk_sf(eng_clk_sf), .eng_clk_hs(eng_clk_hs),
        .eng_cfg(eng_cfg), .eng_tx(eng_tx), .eng_done(eng_done),
        .eng_err(eng_err), .eng_rx(eng_rx)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Reverse the order of the lowest n bytes; other bytes become zero.
    function automatic logic [63:0] flip(input logic [63:0] v, input int n);
        byte unsigned q[$];
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) q.push_front(v[8*i +: 8]);
        for (int i = 0; i < n; i++) r[8*i +: 8] = q[i];
        return r;
    endfunction

    // Reference model state.
    logic [4:0]  m_sts, m_msk;
    logic        m_busy, m_start;
    logic [1:0]  m_kind;
    int          m_wn, m_rn;
    logic [31:0] m_w0, m_w1;
    logic [15:0] m_cfg;
    logic [9:0]  m_addr;

    always @(posedge clk) begin
        logic wr, cmdw, done_ev, acc;
        logic [4:0] setv;
        logic [63:0] pk;
        if (!rst_n) begin
            m_sts = 0; m_msk = 0; m_busy = 0; m_start = 0; m_kind = 0;
            m_wn = 1; m_rn = 1; m_w0 = 0; m_w1 = 0; m_cfg = 16'h3302; m_addr = 0;
        end else begin
            wr = bus_sel && bus_wr;
            cmdw = wr && bus_off == 6'h0C;
            done_ev = m_busy && eng_done;
            setv = done_ev ? {eng_err, 1'b1} : 5'd0;
            if (cmdw && m_busy) setv[4] = 1'b1;
            if (wr && bus_off == 6'h1C) m_sts = m_sts & ~bus_wdata[4:0];
            m_sts = m_sts | setv;
            if (wr && bus_off == 6'h20) m_msk = bus_wdata[4:0];
            if (wr && bus_off == 6'h08) m_cfg = bus_wdata[15:0] & 16'hFFF3;
            if (wr && bus_off == 6'h10) m_addr = bus_wdata[9:0];
            if (done_ev && m_kind != 2'd0) begin
                pk = flip(eng_rx, m_rn);
                m_w0 = pk[31:0]; m_w1 = pk[63:32];
            end else if (!m_busy) begin
                if (wr && bus_off == 6'h14) m_w0 = bus_wdata;
                if (wr && bus_off == 6'h18) m_w1 = bus_wdata;
            end
            acc = cmdw && !m_busy && bus_wdata[9:8] != 2'd3;
            m_start = acc;
            if (acc) begin
                m_busy = 1'b1; m_kind = bus_wdata[9:8];
                m_wn = int'(bus_wdata[6:4]) + 1; m_rn = int'(bus_wdata[2:0]) + 1;
            end else if (done_ev) begin
                m_busy = 1'b0;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 eng_start", eng_start, m_start);
            chk("R9 irq", irq, |(m_sts & m_msk));
            chk("R3 eng_kind", eng_kind, m_kind);
            chk("R4 eng_taddr", eng_taddr, m_cfg[7] ? m_addr : {3'b0, m_addr[6:0]});
            chk("R5 eng_tx", eng_tx, (m_kind == 2'd1) ? 64'd0 : flip({m_w1, m_w0}, m_wn));
        end
    end

    task automatic bwrite(input logic [5:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rchk(input string what, input logic [5:0] off, input logic [31:0] exp);
        @(negedge clk);
        bus_off = off;
        #2;
        chk(what, bus_rdata, exp);
    endtask

    task automatic finish_xfer(input logic [3:0] err, input logic [63:0] rx);
        @(negedge clk);
        eng_done = 1; eng_err = err; eng_rx = rx;
        @(negedge clk);
        eng_done = 0; eng_err = 0; eng_rx = 64'hA5A5_A5A5_A5A5_A5A5;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rchk("R1 clk_sf", 6'h00, 32'h301F);
        rchk("R1 clk_hs", 6'h04, 32'h301F);
        rchk("R1 cfg", 6'h08, 32'h3302);
        rchk("R1 status", 6'h1C, 0);
        rchk("R1 mask", 6'h20, 0);
        rchk("R1 busy", 6'h24, 0);
        rchk("R1 word0", 6'h14, 0);
        chk("R1 irq", irq, 0);
        // R2 field masks
        bwrite(6'h00, 32'hFFFF_FFFF);
        rchk("R2 clk_sf mask", 6'h00, 32'hF3FF);
        bwrite(6'h04, 32'h0000_5C21);
        rchk("R2 clk_hs mask", 6'h04, 32'h5021);
        bwrite(6'h08, 32'hFFFF_FFFF);
        rchk("R2 cfg mask", 6'h08, 32'hFFF3);
        // R4 address width
        bwrite(6'h10, 32'h3A5);
        #2 chk("R4 ten-bit address", eng_taddr, 10'h3A5);
        bwrite(6'h08, 32'h3302);
        #2 chk("R4 seven-bit address", eng_taddr, 10'h025);
        rchk("R4 address readback", 6'h10, 32'h3A5);
        bwrite(6'h20, 32'h1);
        // R3/R5 four-byte write
        bwrite(6'h14, 32'h4433_2211);
        bwrite(6'h0C, 32'h0000_0030);
        chk("R3 start pulse", eng_start, 1);
        chk("R3 wcnt", eng_wcnt_m1, 3);
        chk("R5 tx order", eng_tx, 64'h0000_0000_1122_3344);
        rchk("R3 busy reads 1", 6'h24, 1);
        // R12 data write while busy
        bwrite(6'h14, 32'hDEAD_BEEF);
        rchk("R12 word0 kept", 6'h14, 32'h4433_2211);
        // R10 command while busy
        bwrite(6'h0C, 32'h0000_0177);
        chk("R10 kind kept", eng_kind, 0);
        chk("R10 rcnt kept", eng_rcnt_m1, 0);
        rchk("R10 bus-busy flag", 6'h1C, 32'h10);
        chk("R9 masked flag no irq", irq, 0);
        finish_xfer(4'b0000, 64'h0);
        rchk("R6 done flag", 6'h1C, 32'h11);
        rchk("R6 busy cleared", 6'h24, 0);
        chk("R9 irq on done", irq, 1);
        rchk("R7 write-only keeps word0", 6'h14, 32'h4433_2211);
        // R8 clear
        bwrite(6'h1C, 32'h1F);
        rchk("R8 cleared", 6'h1C, 0);
        chk("R8 irq dropped", irq, 0);
        // R7 three-byte read
        bwrite(6'h0C, 32'h0000_0102);
        finish_xfer(4'b0000, 64'hFFFF_FFFF_FFC3_B2A1);
        rchk("R7 read3 word0", 6'h14, 32'h00A1_B2C3);
        rchk("R7 read3 word1", 6'h18, 32'h0);
        // R5/R6/R7 eight-byte write then read with several errors
        bwrite(6'h1C, 32'h1F);
        bwrite(6'h14, 32'h0403_0201);
        bwrite(6'h18, 32'h0807_0605);
        bwrite(6'h0C, 32'h0000_0277);
        chk("R5 tx eight bytes", eng_tx, 64'h0102_0304_0506_0708);
        finish_xfer(4'b1011, 64'h1122_3344_5566_7788);
        rchk("R6 all error flags", 6'h1C, 32'h17);
        rchk("R7 read8 word0", 6'h14, 32'h4433_2211);
        rchk("R7 read8 word1", 6'h18, 32'h8877_6655);
        // R11 reserved kind
        bwrite(6'h1C, 32'h1F);
        bwrite(6'h0C, 32'h0000_0300);
        chk("R11 no start", eng_start, 0);
        rchk("R11 stays idle", 6'h24, 0);
        rchk("R11 status unchanged", 6'h1C, 0);
        // R13 idle done
        finish_xfer(4'b1111, 64'h0);
        rchk("R13 status unchanged", 6'h1C, 0);
        rchk("R13 busy unchanged", 6'h24, 0);
        // R8 set wins over clear in the same cycle
        bwrite(6'h0C, 32'h0000_0000);
        @(negedge clk);
        eng_done = 1; eng_err = 0;
        bus_sel = 1; bus_wr = 1; bus_off = 6'h1C; bus_wdata = 32'h1;
        @(negedge clk);
        eng_done = 0; bus_sel = 0; bus_wr = 0;
        rchk("R8 set wins", 6'h1C, 32'h1);
        // R9 mask off
        bwrite(6'h20, 32'h0);
        chk("R9 masked irq", irq, 0);
        bwrite(6'h20, 32'h1);
        chk("R9 unmasked irq", irq, 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule